// File: doc/BRIEF.md
# APB3 Stream Bridge

This peripheral sits on an APB3 bus as a slave and links a processor to fabric logic through two registers. Words arriving from the fabric on a ready/valid stream are held in a 32-entry FIFO. The processor collects them one at a time by reading the inbound register. That read never waits. It returns the oldest word together with a flag that says whether the word is real, and it removes the word only when the flag is set.

Words going the other way need no buffering. Every processor write to the outbound register sends a one-cycle valid pulse to the fabric, carrying the written payload. The fabric cannot push back. Payloads are 31 bits wide: a 7-bit command in bits 30:24 and 24 bits of data in bits 23:0.

The bus, the FIFO and both sides of the fabric all run on one clock, so the block has no synchronisers. Every access completes in its enable phase with no wait states.

Top module: `apb_stream_bridge`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` is 0, and the FIFO is empty.
- R2: `pready_o` is 1 and `pslverr_o` is 0 in every access, whatever the address or direction.
- R3: A read of offset 0x00 while the FIFO holds data returns 1 in bit 31 and the oldest stored payload in bits 30:0. The command (bits 30:24) and data (bits 23:0) fields pass unchanged, and words come out in arrival order.
- R4: A read of offset 0x00 while the FIFO is empty returns 0x00000000, flag included, and removes nothing. Only a read that returns flag 1 pops the FIFO.
- R5: The FIFO accepts a word when `in_valid_i` and `in_ready_o` are both high at a clock edge. `in_ready_o` is 0 while 32 words are stored, and words offered then are not stored. Popping a word from a full FIFO raises `in_ready_o` again.
- R6: A write to offset 0x04 sets `out_valid_o` for exactly one cycle, starting the cycle after the enable phase, with `out_data_o` equal to `pwdata_i[30:0]`. Bit 31 of the write data is dropped.
- R7: `out_valid_o` stays 0 in every cycle not caused by an R6 write. A setup phase without an enable phase produces no pulse, and a read of offset 0x04 produces no pulse.
- R8: Reads of any address other than 0x00 return 0. Writes to any address other than 0x04, including 0x00, neither pulse the output nor change the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the bus and the stream sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable phase |
| pwrite_i | input | 1 | APB direction, 1 = write |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, held at 1 |
| pslverr_o | output | 1 | APB error, held at 0 |
| in_valid_i | input | 1 | Inbound stream valid |
| in_ready_o | output | 1 | Inbound stream ready; low when the FIFO is full |
| in_data_i | input | 31 | Inbound payload: command in bits 30:24, data in bits 23:0 |
| out_valid_o | output | 1 | Outbound one-cycle valid pulse |
| out_data_o | output | 31 | Outbound payload |

## Verification
The hardest state to reach is a full FIFO that keeps being offered data. The stimulus offers 32 words and then 3 more while `in_ready_o` is low. It then drains through the register port and expects exactly the first 32 words in order, followed by an empty read. That sequence shows the extra words were dropped and that a pop from full restores ready. The stimulus also hides writes to 0x00 and to unmapped addresses between pushes and reads. A scoreboard of expected pulses and expected FIFO words then exposes any stray pulse or lost word.

// File: rtl/apb_strm_pkg.sv
package apb_strm_pkg;
  localparam int CMD_W      = 7;
  localparam int DATA_W     = 24;
  localparam int PAYLOAD_W  = CMD_W + DATA_W;
  localparam int BUS_W      = PAYLOAD_W + 1;
  localparam int ADDR_W     = 12;
  localparam int FIFO_DEPTH = 32;

  localparam logic [ADDR_W-1:0] OFS_IN  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_OUT = 12'h004;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } payload_t;
endpackage

// File: rtl/strm_fifo.sv
module strm_fifo #(
  parameter int W     = 31,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [PW:0]  wr_ptr_q, rd_ptr_q;
  logic         do_push, do_pop;

  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[PW] != rd_ptr_q[PW]) &&
                   (wr_ptr_q[PW-1:0] == rd_ptr_q[PW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q[PW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // storage needs no reset: ptrs gate every read
  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q[PW-1:0]] <= push_data_i;
  end
endmodule

// File: rtl/apb_slot_decode.sv
module apb_slot_decode
  import apb_strm_pkg::*;
(
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              rd_in_o,
  output logic              wr_out_o
);
  logic access, hit_in, hit_out;

  assign access   = psel_i && penable_i;
  assign hit_in   = (paddr_i == OFS_IN);
  assign hit_out  = (paddr_i == OFS_OUT);
  assign rd_in_o  = access && !pwrite_i && hit_in;
  assign wr_out_o = access && pwrite_i && hit_out;
endmodule

// File: rtl/flow_pulse_gen.sv
module flow_pulse_gen #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/apb_stream_bridge.sv
module apb_stream_bridge
  import apb_strm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psel_i,
  input  logic                 penable_i,
  input  logic                 pwrite_i,
  input  logic [ADDR_W-1:0]    paddr_i,
  input  logic [BUS_W-1:0]     pwdata_i,
  output logic [BUS_W-1:0]     prdata_o,
  output logic                 pready_o,
  output logic                 pslverr_o,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [PAYLOAD_W-1:0] in_data_i,
  output logic                 out_valid_o,
  output logic [PAYLOAD_W-1:0] out_data_o
);
  logic                 rd_in, wr_out;
  logic                 fifo_empty, fifo_full, fifo_pop;
  logic [PAYLOAD_W-1:0] fifo_head;
  logic                 unused_wbit;

  assign unused_wbit = pwdata_i[BUS_W-1];
  assign pready_o    = 1'b1;
  assign pslverr_o   = 1'b0;

  apb_slot_decode u_dec (
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .rd_in_o   (rd_in),
    .wr_out_o  (wr_out)
  );

  strm_fifo #(.W(PAYLOAD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (in_valid_i),
    .push_data_i (in_data_i),
    .pop_i       (fifo_pop),
    .head_o      (fifo_head),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full)
  );

  assign in_ready_o = !fifo_full;
  assign fifo_pop   = rd_in && !fifo_empty;

  always_comb begin
    prdata_o = '0;
    if (fifo_pop) prdata_o = {1'b1, fifo_head};
  end

  flow_pulse_gen #(.W(PAYLOAD_W)) u_flow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (wr_out),
    .data_i  (pwdata_i[PAYLOAD_W-1:0]),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );
endmodule

// File: rtl/apb_stream_bridge_chk.sv
module apb_stream_bridge_chk
  import apb_strm_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 psel_i,
  input logic                 penable_i,
  input logic                 pwrite_i,
  input logic [ADDR_W-1:0]    paddr_i,
  input logic [BUS_W-1:0]     pwdata_i,
  input logic [BUS_W-1:0]     prdata_o,
  input logic                 in_ready_o,
  input logic                 out_valid_o,
  input logic [PAYLOAD_W-1:0] out_data_o
);
  logic rd_acc, wr_out_acc;
  assign rd_acc     = psel_i && penable_i && !pwrite_i;
  assign wr_out_acc = psel_i && penable_i && pwrite_i && (paddr_i == OFS_OUT);

  AST_PULSE_HAS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(wr_out_acc)); // R7

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o); // R6

  AST_PULSE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o == $past(pwdata_i[PAYLOAD_W-1:0])); // R6

  AST_WRITE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out_acc |=> out_valid_o); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i == OFS_IN && !prdata_o[BUS_W-1]) |-> prdata_o == '0); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i != OFS_IN) |-> prdata_o == '0); // R8

  AST_POP_FREES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && paddr_i == OFS_IN && prdata_o[BUS_W-1]) |=> in_ready_o); // R5
endmodule

bind apb_stream_bridge apb_stream_bridge_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .psel_i      (psel_i),
  .penable_i   (penable_i),
  .pwrite_i    (pwrite_i),
  .paddr_i     (paddr_i),
  .pwdata_i    (pwdata_i),
  .prdata_o    (prdata_o),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/apb_stream_bridge_test.sv
module apb_stream_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [11:0] paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o, pslverr_o;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [30:0] in_data_i = '0;
  logic        out_valid_o;
  logic [30:0] out_data_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [30:0] in_q[$];
  logic [30:0] out_q[$];

  always #4 clk_i = ~clk_i;

  apb_stream_bridge uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic apb_read(input logic [11:0] addr, output logic [31:0] data);
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b0; paddr_i = addr;
    @(negedge clk_i);
    penable_i = 1'b1;
    #1;
    data = prdata_o;
    chk(pready_o === 1'b1 && pslverr_o === 1'b0, "R2", {30'd0, pready_o, pslverr_o}, 32'h2);
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0;
  endtask

  task automatic apb_write(input logic [11:0] addr, input logic [31:0] data, input bit expect_pulse);
    if (expect_pulse) out_q.push_back(data[30:0]);
    @(negedge clk_i);
    psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b1; paddr_i = addr; pwdata_i = data;
    @(negedge clk_i);
    penable_i = 1'b1;
    #1;
    chk(pready_o === 1'b1 && pslverr_o === 1'b0, "R2", {30'd0, pready_o, pslverr_o}, 32'h2);
    @(negedge clk_i);
    psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic read_expect(input string req);
    logic [31:0] got, exp;
    exp = (in_q.size() == 0) ? 32'h0 : {1'b1, in_q[0]};
    apb_read(12'h000, got);
    chk(got === exp, req, got, exp);
    if (in_q.size() != 0) void'(in_q.pop_front());
  endtask

  task automatic push_word(input logic [30:0] d);
    bit exp_rdy;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = d;
    #1;
    exp_rdy = (in_q.size() < 32);
    chk(in_ready_o === exp_rdy, "R5", {31'd0, in_ready_o}, {31'd0, exp_rdy});
    if (exp_rdy) in_q.push_back(d);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  // monitor: every outbound pulse must match the next expected write (R6, R7)
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o === 1'b1) begin
      if (out_q.size() == 0) chk(1'b0, "R7 unexpected pulse", {1'b0, out_data_o}, 32'h0);
      else begin
        chk(out_data_o === out_q[0], "R6", {1'b0, out_data_o}, {1'b0, out_q[0]});
        void'(out_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(in_ready_o === 1'b1, "R1 ready", {31'd0, in_ready_o}, 32'h1);
    chk(out_valid_o === 1'b0, "R1 valid", {31'd0, out_valid_o}, 32'h0);
    read_expect("R1 empty after reset");
    read_expect("R4 empty read");

    // R3: field patterns, in order
    push_word({7'h7F, 24'h000000});
    push_word({7'h00, 24'hFFFFFF});
    push_word({7'h2A, 24'h123456});
    push_word({7'h55, 24'hA5A5A5});
    read_expect("R3");
    read_expect("R3");
    read_expect("R3");
    read_expect("R3");
    read_expect("R4 read after drain");

    // R6: writes to output
    apb_write(12'h004, 32'h8000_0001, 1'b1);
    apb_write(12'h004, 32'h7FFF_FFFF, 1'b1);
    apb_write(12'h004, {1'b0, 7'h11, 24'hABCDEF}, 1'b1);

    // R7: setup phase only, and read of 0x04
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = 12'h004; pwdata_i = 32'h1234;
    @(negedge clk_i);
    psel_i = 1'b0; pwrite_i = 1'b0;
    apb_read(12'h004, rd);
    chk(rd === 32'h0, "R8 read of 0x04", rd, 32'h0);

    // R8: writes elsewhere change nothing
    push_word({7'h03, 24'h0C0FFE});
    apb_write(12'h000, 32'hFFFF_FFFF, 1'b0);
    apb_write(12'h010, 32'h0000_5555, 1'b0);
    apb_write(12'h008, 32'h0000_AAAA, 1'b0);
    apb_read(12'h100, rd);
    chk(rd === 32'h0, "R8 unmapped read", rd, 32'h0);
    read_expect("R8 fifo kept after stray writes");
    read_expect("R4 empty");

    // R5: fill, overflow offers, drain
    for (int i = 0; i < 35; i++) push_word({i[6:0], 24'h100000 + i[23:0]});
    #1;
    chk(in_ready_o === 1'b0, "R5 full", {31'd0, in_ready_o}, 32'h0);
    read_expect("R5 pop from full");
    #1;
    chk(in_ready_o === 1'b1, "R5 ready after pop", {31'd0, in_ready_o}, 32'h1);
    for (int i = 0; i < 31; i++) read_expect("R5 drain");
    read_expect("R5 empty after drain");

    // interleave: writes between pushes and reads
    push_word({7'h41, 24'h000001});
    apb_write(12'h004, 32'h0000_0042, 1'b1);
    push_word({7'h42, 24'h000002});
    read_expect("R3 interleaved");
    apb_write(12'h004, 32'h0000_0043, 1'b1);
    read_expect("R3 interleaved");
    read_expect("R4 final empty");

    repeat (4) @(negedge clk_i);
    chk(out_q.size() == 0, "R6 all pulses seen", out_q.size(), 32'h0);
    finish_run();
  end
endmodule